// File: doc/BRIEF.md
# Predicated Multi-Element Consensual Branch Unit

The block turns many element-wise comparisons into one branch decision. A start pulse captures two operand vectors and a set of controls: the comparison, a source predicate with its invert, zeroing and fail-on-first flags, the flags of the destination predicate, and the active element count. The unit then tests one element pair per clock and builds a per-element result bitmask.

In a separate closing cycle, the unit reduces that mask to a single taken / not-taken answer. The reduction is one of four consensus rules: all pass, any fails, any passes, or none passes. The destination predicate's invert and zeroing flags pick the rule. With fail-on-first set, the unit stops at the first enabled element whose test is false. It clears every later result bit before the decision is made.

The unit gives the caller a one-cycle completion pulse, the branch verdict, the final mask, and a write strobe for the mask. Branch target arithmetic and register-file access are left to the surrounding pipeline.

Top module: `cbranch_unit`

## Requirements
- R1: `op_i[1:0]` selects the test: 0 = equal, 1 = not equal, 2 = less than, 3 = greater or equal. `op_i[2]` = 1 makes less-than and greater-or-equal signed; 0 makes them unsigned. Element i occupies bits [i*EW +: EW] of each operand vector.
- R2: The consensus rule is chosen by {zeroing, invert} of the destination flags. With ps the effective predicate:
  - 00 is AND: taken when (result & ps) == ps.
  - 01 is NAND: taken when (result & ps) != ps.
  - 10 is OR: taken when result != 0.
  - 11 is NOR: taken when result == 0.
- R3: When `dst_present_i` is 0, both destination flags are treated as 0, so the AND rule applies.
- R4: The mask starts as ones on bits 0..vl-1 when there is no destination or when source zeroing is set. Otherwise it starts as all zeros. Bits at vl and above are always 0.
- R5: The effective predicate is ps = (`pmask_i` XOR invert) limited to bits below vl. An enabled element stores its test outcome. A masked-off element keeps its start bit, or gets 0 if source zeroing is set.
- R6: Without fail-on-first, every element 0..vl-1 is visited. If start is sampled at edge 0, `done_o` is high for exactly one cycle after edge vl+1.
- R7: With fail-on-first, an enabled element k whose test is false ends the scan. Bit k and all bits above k read 0, and `done_o` rises after edge k+2.
- R8: `result_we_o` pulses together with `done_o` exactly when a destination is present.
- R9: A start pulse that arrives while a scan is in progress is ignored. Only one completion follows.
- R10: After reset, `done_o`, `branch_o`, `result_we_o` and `result_o` are all 0.
- R11: A `vl_i` above VL is treated as VL. A `vl_i` of 0 completes after edge 1 with an empty mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a scan (sampled when idle) |
| op_i | input | 3 | Comparison select, bit 2 = signed |
| src_a_i | input | VL*EW | First operand elements |
| src_b_i | input | VL*EW | Second operand elements |
| pmask_i | input | VL | Source predicate bits |
| pinv_i | input | 1 | Invert source predicate |
| pzero_i | input | 1 | Source zeroing mode |
| ffirst_i | input | 1 | Fail-on-first mode |
| dst_present_i | input | 1 | Destination predicate exists |
| dst_inv_i | input | 1 | Destination invert flag |
| dst_zero_i | input | 1 | Destination zeroing flag |
| vl_i | input | $clog2(VL+1) | Active element count |
| done_o | output | 1 | One-cycle completion pulse |
| branch_o | output | 1 | Branch decision, valid with done_o |
| result_o | output | VL | Final result mask |
| result_we_o | output | 1 | Mask write strobe |

## Verification
The element index, the held mask and the held mode are internal state. A fault in any of them reaches the ports only at completion, because the mask and verdict are published in a single registered cycle.

- A wrong index moves the completion pulse away from edge vl+1, or away from edge k+2 under fail-on-first.
- A corrupted mask bit or a wrong start value shows up as a wrong `result_o` bit at that same pulse.
- A wrong mode bit flips `branch_o` only for the mask/predicate pairs where the four rules disagree, so the stimulus deliberately includes such pairs.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  typedef enum logic [1:0] {
    CMP_EQ = 2'd0,
    CMP_NE = 2'd1,
    CMP_LT = 2'd2,
    CMP_GE = 2'd3
  } cmp_e;

  // encoded as {zeroing, invert} of the destination flags
  typedef enum logic [1:0] {
    CONS_AND  = 2'b00,
    CONS_NAND = 2'b01,
    CONS_OR   = 2'b10,
    CONS_NOR  = 2'b11
  } cons_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DECIDE
  } st_e;

  function automatic cons_e cons_mode(input logic present, input logic inv, input logic zero);
    return present ? cons_e'({zero, inv}) : CONS_AND;
  endfunction

endpackage

// File: rtl/cbr_cmp.sv
module cbr_cmp #(
  parameter int EW = 16
) (
  input  logic [EW-1:0] a_i,
  input  logic [EW-1:0] b_i,
  input  logic [2:0]    op_i,
  output logic          pass_o
);
  import cbr_pkg::*;

  logic lt;

  always_comb begin
    lt = op_i[2] ? ($signed(a_i) < $signed(b_i)) : (a_i < b_i);
    case (cmp_e'(op_i[1:0]))
      CMP_EQ:  pass_o = (a_i == b_i);
      CMP_NE:  pass_o = (a_i != b_i);
      CMP_LT:  pass_o = lt;
      default: pass_o = !lt;
    endcase
  end

endmodule

// File: rtl/cbr_decide.sv
module cbr_decide #(
  parameter int VL = 8
) (
  input  cbr_pkg::cons_e  mode_i,
  input  logic [VL-1:0]   res_i,
  input  logic [VL-1:0]   ps_i,
  output logic            branch_o
);
  import cbr_pkg::*;

  logic all_pass;
  logic any_set;

  always_comb begin
    all_pass = ((res_i & ps_i) == ps_i);
    any_set  = |res_i;
    case (mode_i)
      CONS_AND:  branch_o = all_pass;
      CONS_NAND: branch_o = !all_pass;
      CONS_OR:   branch_o = any_set;
      default:   branch_o = !any_set;
    endcase
  end

endmodule

// File: rtl/cbr_seq.sv
module cbr_seq #(
  parameter int VL = 8,
  parameter int EW = 16,
  localparam int CW   = $clog2(VL + 1),
  localparam int IDXW = (VL > 1) ? $clog2(VL) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       op_i,
  input  logic [VL*EW-1:0] src_a_i,
  input  logic [VL*EW-1:0] src_b_i,
  input  logic [VL-1:0]    pmask_i,
  input  logic             pinv_i,
  input  logic             pzero_i,
  input  logic             ffirst_i,
  input  logic             dst_present_i,
  input  logic             dst_inv_i,
  input  logic             dst_zero_i,
  input  logic [CW-1:0]    vl_i,
  input  logic             pass_i,
  output logic [EW-1:0]    elem_a_o,
  output logic [EW-1:0]    elem_b_o,
  output logic [2:0]       op_o,
  output logic             decide_o,
  output logic             we_o,
  output cbr_pkg::cons_e   mode_o,
  output logic [VL-1:0]    res_o,
  output logic [VL-1:0]    ps_o
);
  import cbr_pkg::*;

  st_e              state_q;
  logic [IDXW-1:0]  idx_q;
  logic [CW-1:0]    vl_q;
  logic [VL*EW-1:0] a_q, b_q;
  logic [2:0]       op_q;
  logic [VL-1:0]    ps_q, res_q;
  logic             pzero_q, ff_q, we_q;
  cons_e            mode_q;

  logic [CW-1:0]    vl_eff;
  logic [VL-1:0]    start_mask, below_idx, res_nxt;
  logic [EW-1:0]    a_el [VL];
  logic [EW-1:0]    b_el [VL];
  logic             stop, last;

  assign vl_eff = (vl_i > CW'(VL)) ? CW'(VL) : vl_i;

  for (genvar g = 0; g < VL; g++) begin : g_lane
    assign a_el[g]       = a_q[g*EW +: EW];
    assign b_el[g]       = b_q[g*EW +: EW];
    assign start_mask[g] = (CW'(g) < vl_eff);
    assign below_idx[g]  = (IDXW'(g) < idx_q);
  end

  assign elem_a_o = a_el[idx_q];
  assign elem_b_o = b_el[idx_q];
  assign op_o     = op_q;

  always_comb begin
    res_nxt = res_q;
    stop    = 1'b0;
    if (ps_q[idx_q]) begin
      res_nxt[idx_q] = pass_i;
      if (ff_q && !pass_i) begin
        res_nxt = res_q & below_idx;  // element idx and all above read zero
        stop    = 1'b1;
      end
    end else if (pzero_q) begin
      res_nxt[idx_q] = 1'b0;
    end
  end

  assign last = ((CW'(idx_q) + CW'(1)) == vl_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      vl_q    <= '0;
      a_q     <= '0;
      b_q     <= '0;
      op_q    <= '0;
      ps_q    <= '0;
      res_q   <= '0;
      pzero_q <= 1'b0;
      ff_q    <= 1'b0;
      we_q    <= 1'b0;
      mode_q  <= CONS_AND;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          idx_q   <= '0;
          vl_q    <= vl_eff;
          a_q     <= src_a_i;
          b_q     <= src_b_i;
          op_q    <= op_i;
          ps_q    <= (pmask_i ^ {VL{pinv_i}}) & start_mask;
          res_q   <= (!dst_present_i || pzero_i) ? start_mask : '0;
          pzero_q <= pzero_i;
          ff_q    <= ffirst_i;
          we_q    <= dst_present_i;
          mode_q  <= cons_mode(dst_present_i, dst_inv_i, dst_zero_i);
          state_q <= (vl_eff == '0) ? ST_DECIDE : ST_RUN;
        end
        ST_RUN: begin
          res_q <= res_nxt;
          if (stop || last) state_q <= ST_DECIDE;
          else              idx_q   <= idx_q + IDXW'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign decide_o = (state_q == ST_DECIDE);
  assign we_o     = we_q;
  assign mode_o   = mode_q;
  assign res_o    = res_q;
  assign ps_o     = ps_q;

  // R6: the scan never walks past the active count
  a_r6_idx_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> (CW'(idx_q) < vl_q));

  // R7: a false enabled test under fail-on-first ends the scan next cycle
  a_r7_ffirst_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && ff_q && ps_q[idx_q] && !pass_i) |=> (state_q == ST_DECIDE));

  // R9: an in-flight scan keeps its captured count whatever start does
  a_r9_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |=> $stable(vl_q) && (state_q != ST_IDLE));

  // R4: no mask bit at or above the active count
  a_r4_mask_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> ((res_q | ps_q) >> vl_q) == '0);

endmodule

// File: rtl/cbranch_unit.sv
module cbranch_unit #(
  parameter int VL = 8,
  parameter int EW = 16,
  localparam int CW = $clog2(VL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       op_i,
  input  logic [VL*EW-1:0] src_a_i,
  input  logic [VL*EW-1:0] src_b_i,
  input  logic [VL-1:0]    pmask_i,
  input  logic             pinv_i,
  input  logic             pzero_i,
  input  logic             ffirst_i,
  input  logic             dst_present_i,
  input  logic             dst_inv_i,
  input  logic             dst_zero_i,
  input  logic [CW-1:0]    vl_i,
  output logic             done_o,
  output logic             branch_o,
  output logic [VL-1:0]    result_o,
  output logic             result_we_o
);
  import cbr_pkg::*;

  logic [EW-1:0] elem_a, elem_b;
  logic [2:0]    op_cur;
  logic          pass, decide, we, branch_nxt;
  cons_e         mode;
  logic [VL-1:0] res, ps;

  cbr_seq #(.VL(VL), .EW(EW)) i_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .op_i          (op_i),
    .src_a_i       (src_a_i),
    .src_b_i       (src_b_i),
    .pmask_i       (pmask_i),
    .pinv_i        (pinv_i),
    .pzero_i       (pzero_i),
    .ffirst_i      (ffirst_i),
    .dst_present_i (dst_present_i),
    .dst_inv_i     (dst_inv_i),
    .dst_zero_i    (dst_zero_i),
    .vl_i          (vl_i),
    .pass_i        (pass),
    .elem_a_o      (elem_a),
    .elem_b_o      (elem_b),
    .op_o          (op_cur),
    .decide_o      (decide),
    .we_o          (we),
    .mode_o        (mode),
    .res_o         (res),
    .ps_o          (ps)
  );

  cbr_cmp #(.EW(EW)) i_cmp (
    .a_i    (elem_a),
    .b_i    (elem_b),
    .op_i   (op_cur),
    .pass_o (pass)
  );

  cbr_decide #(.VL(VL)) i_decide (
    .mode_i   (mode),
    .res_i    (res),
    .ps_i     (ps),
    .branch_o (branch_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      branch_o    <= 1'b0;
      result_o    <= '0;
      result_we_o <= 1'b0;
    end else begin
      done_o      <= decide;
      result_we_o <= decide && we;
      if (decide) begin
        branch_o <= branch_nxt;
        result_o <= res;
      end
    end
  end

  // R6: completion is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8: the mask strobe never appears without completion
  a_r8_we_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_we_o |-> done_o);

  // R2: OR and NOR verdicts agree with the published mask
  a_r2_or_rule: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode == CONS_OR) |-> (branch_o == (result_o != '0)));

  a_r2_nor_rule: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode == CONS_NOR) |-> (branch_o == (result_o == '0)));

endmodule

// File: tb/test_cbranch_unit.sv
`timescale 1ns/1ps
module test_cbranch_unit;

  localparam int VL = 8;
  localparam int EW = 16;
  localparam int CW = $clog2(VL + 1);

  localparam logic [VL*EW-1:0] A0 = 128'h0008_0007_0006_0005_0004_0003_0002_0001;
  localparam logic [VL*EW-1:0] B0 = 128'h0000_0007_0000_0005_0000_0003_0000_0001;
  localparam logic [VL*EW-1:0] A1 = 128'hFFFF_0002_FFFF_0002_FFFF_0002_FFFF_0002;
  localparam logic [VL*EW-1:0] B1 = 128'h0001_0001_0001_0001_0001_0001_0001_0001;

  typedef struct packed {
    logic [2:0]       op;
    logic [VL*EW-1:0] a;
    logic [VL*EW-1:0] b;
    logic [VL-1:0]    pmask;
    logic             pinv;
    logic             pzero;
    logic             ff;
    logic             dp;
    logic             dinv;
    logic             dzero;
    logic [CW-1:0]    vl;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t TBL [NVEC] = '{
    '{3'b000, A0, B0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8},
    '{3'b001, A0, B0, 8'hF0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd8},
    '{3'b110, A1, B1, 8'h0F, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd8},
    '{3'b011, A1, B1, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd6},
    '{3'b010, A1, B1, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd8},
    '{3'b000, A1, A1, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd5},
    '{3'b111, A0, B1, 8'hAA, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8},
    '{3'b001, A1, B1, 8'h55, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd7}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [2:0]       op = '0;
  logic [VL*EW-1:0] src_a = '0, src_b = '0;
  logic [VL-1:0]    pmask = '0;
  logic             pinv = 1'b0, pzero = 1'b0, ffirst = 1'b0;
  logic             dp = 1'b0, dinv = 1'b0, dzero = 1'b0;
  logic [CW-1:0]    vl = '0;
  logic             done, branch, we;
  logic [VL-1:0]    result;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cbranch_unit #(.VL(VL), .EW(EW)) i_cbranch_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .src_a_i(src_a), .src_b_i(src_b), .pmask_i(pmask), .pinv_i(pinv),
    .pzero_i(pzero), .ffirst_i(ffirst), .dst_present_i(dp),
    .dst_inv_i(dinv), .dst_zero_i(dzero), .vl_i(vl),
    .done_o(done), .branch_o(branch), .result_o(result), .result_we_o(we)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic test_el(input vec_t v, input int i);
    logic [EW-1:0] x, y;
    logic lt;
    x  = v.a[i*EW +: EW];
    y  = v.b[i*EW +: EW];
    lt = v.op[2] ? ($signed(x) < $signed(y)) : (x < y);
    case (v.op[1:0])
      2'd0: return x == y;
      2'd1: return x != y;
      2'd2: return lt;
      default: return !lt;
    endcase
  endfunction

  // reference built from R1..R7, R11
  task automatic model(input vec_t v, output logic [VL-1:0] r, output logic br,
                       output int cyc);
    int vle;
    logic [VL-1:0] m, ps;
    logic inv, z, p, allp;
    vle = (v.vl > VL) ? VL : int'(v.vl);
    m = '0;
    for (int i = 0; i < vle; i++) m[i] = 1'b1;
    ps  = (v.pmask ^ {VL{v.pinv}}) & m;
    r   = (!v.dp || v.pzero) ? m : '0;
    cyc = vle + 1;
    for (int i = 0; i < vle; i++) begin
      if (ps[i]) begin
        p = test_el(v, i);
        r[i] = p;
        if (v.ff && !p) begin
          for (int j = i; j < VL; j++) r[j] = 1'b0;
          cyc = i + 2;
          break;
        end
      end else if (v.pzero) r[i] = 1'b0;
    end
    inv  = v.dp ? v.dinv : 1'b0;
    z    = v.dp ? v.dzero : 1'b0;
    allp = ((r & ps) == ps);
    case ({z, inv})
      2'b00: br = allp;
      2'b01: br = !allp;
      2'b10: br = (r != 0);
      default: br = (r == 0);
    endcase
  endtask

  task automatic apply(input vec_t v);
    op = v.op; src_a = v.a; src_b = v.b; pmask = v.pmask; pinv = v.pinv;
    pzero = v.pzero; ffirst = v.ff; dp = v.dp; dinv = v.dinv;
    dzero = v.dzero; vl = v.vl;
  endtask

  // starts at a negedge, returns the edge count at which done was seen
  task automatic run(input vec_t v, output int n);
    apply(v);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 0;
    if (done) n = 1;
    while (n == 0 || (n < 100 && !done)) begin
      if (done) break;
      @(posedge clk);
      @(negedge clk);
      n++;
      if (done) break;
    end
    if (n == 0) n = 1;
  endtask

  function automatic vec_t mk(input logic [2:0] o, input logic [VL*EW-1:0] a,
      input logic [VL*EW-1:0] b, input logic [VL-1:0] pm, input logic pi,
      input logic pz, input logic f, input logic d, input logic di,
      input logic dz, input logic [CW-1:0] l);
    vec_t v;
    v = '{o, a, b, pm, pi, pz, f, d, di, dz, l};
    return v;
  endfunction

  task automatic directed(input vec_t v, input string req, input logic [VL-1:0] er,
                          input logic eb, input int ec, input logic ewe);
    int n;
    run(v, n);
    check(n == ec, req, "done edge", n, ec);
    check(result == er, req, "result mask", result, er);
    check(branch == eb, req, "branch", branch, eb);
    check(we == ewe, req, "write strobe", we, ewe);
    @(negedge clk);
    check(!done, req, "done pulse width", done, 0);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL R6 watchdog expired: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [VL-1:0] er;
    logic eb;
    int ec, n;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!done && !branch && !we && result == 0, "R10", "reset outputs",
          {done, branch, we, result}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk against the requirement model (R1, R2, R4, R5, R6, R7)
    for (int k = 0; k < NVEC; k++) begin
      model(TBL[k], er, eb, ec);
      run(TBL[k], n);
      check(n == ec, "R6/R7", "table done edge", n, ec);
      check(result == er, "R1/R4/R5", "table mask", result, er);
      check(branch == eb, "R2", "table branch", branch, eb);
      check(we == TBL[k].dp, "R8", "table strobe", we, TBL[k].dp);
      @(negedge clk);
    end

    // R1: equal/not-equal, unsigned vs signed ordering
    directed(mk(3'b000, A0, B0, 8'hFF, 0, 0, 0, 1, 0, 0, 4'd8), "R1 eq", 8'h55, 1'b0, 9, 1'b1);
    directed(mk(3'b001, A0, B0, 8'hFF, 0, 0, 0, 1, 0, 1, 4'd8), "R1 ne", 8'hAA, 1'b1, 9, 1'b1);
    directed(mk(3'b010, A1, B1, 8'hFF, 0, 0, 0, 1, 0, 1, 4'd8), "R1 ltu", 8'h00, 1'b0, 9, 1'b1);
    directed(mk(3'b110, A1, B1, 8'hFF, 0, 0, 0, 1, 0, 0, 4'd8), "R1 lts", 8'hAA, 1'b0, 9, 1'b1);
    directed(mk(3'b011, A1, B1, 8'hFF, 0, 0, 0, 1, 0, 0, 4'd8), "R1 geu", 8'hFF, 1'b1, 9, 1'b1);
    // R2: same mask 0x55 under the four rules
    directed(mk(3'b000, A0, B0, 8'hFF, 0, 0, 0, 1, 1, 0, 4'd8), "R2 nand", 8'h55, 1'b1, 9, 1'b1);
    directed(mk(3'b000, A0, B0, 8'hFF, 0, 0, 0, 1, 1, 1, 4'd8), "R2 nor", 8'h55, 1'b0, 9, 1'b1);
    // R3: flags ignored without destination; NOR would say not taken
    directed(mk(3'b000, A0, B0, 8'h05, 0, 0, 0, 0, 1, 1, 4'd8), "R3", 8'hFF, 1'b1, 9, 1'b0);
    // R4/R5: start value and zeroing of masked elements
    directed(mk(3'b000, A0, B0, 8'h05, 0, 0, 0, 1, 0, 1, 4'd8), "R4 dst", 8'h05, 1'b1, 9, 1'b1);
    directed(mk(3'b000, A0, B0, 8'h05, 0, 1, 0, 0, 0, 0, 4'd8), "R5 zero", 8'h05, 1'b1, 9, 1'b0);
    directed(mk(3'b000, A0, B0, 8'hFA, 1, 0, 0, 1, 0, 0, 4'd8), "R5 inv", 8'h05, 1'b1, 9, 1'b1);
    // R7: fail-on-first stops at element 1
    directed(mk(3'b000, A0, B0, 8'hFF, 0, 0, 1, 1, 0, 1, 4'd8), "R7", 8'h01, 1'b1, 3, 1'b1);
    directed(mk(3'b000, A0, B0, 8'hFF, 0, 1, 1, 0, 0, 0, 4'd8), "R7 clear", 8'h01, 1'b0, 3, 1'b0);
    // R6/R11: short count, zero count, clamped count
    directed(mk(3'b000, A0, B0, 8'hFF, 0, 0, 0, 1, 0, 1, 4'd3), "R6 vl3", 8'h05, 1'b1, 4, 1'b1);
    directed(mk(3'b000, A0, B0, 8'hFF, 0, 0, 0, 1, 0, 0, 4'd0), "R11 vl0", 8'h00, 1'b1, 1, 1'b1);
    directed(mk(3'b000, A0, B0, 8'hFF, 0, 0, 0, 1, 0, 0, 4'd15), "R11 clamp", 8'h55, 1'b0, 9, 1'b1);

    // R9: a second start during a scan is ignored
    begin
      int seen = 0;
      apply(mk(3'b000, A0, B0, 8'hFF, 0, 0, 0, 1, 0, 1, 4'd8));
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      apply(mk(3'b001, A0, B0, 8'hFF, 0, 0, 0, 1, 1, 1, 4'd2));
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 3;
      ec = 0;
      for (int c = 0; c < 15; c++) begin
        @(negedge clk);
        n++;
        if (done) begin
          seen++;
          if (ec == 0) ec = n;
          check(result == 8'h55, "R9", "busy start mask", result, 8'h55);
          check(branch == 1'b1, "R9", "busy start branch", branch, 1);
        end
      end
      check(ec == 9, "R9", "busy start done edge", ec, 9);
      check(seen == 1, "R9", "completions", seen, 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule